// File: doc/BRIEF.md
# Coherence Request Event Classifier

This block sits at the front of a shared-cache bank controller. It takes one request from a private first-level cache per cycle and turns it into the internal event that the bank's protocol engine acts on. The inputs are the request kind, the ID of the requesting cache, whether the addressed line is resident, the line's sharer bit-vector, whether the indexed set still has a free way, and the dirty bit of the way that replacement has picked as victim.

The inputs are captured in one register stage. The event is then derived combinationally, so the result appears in the cycle after the request is taken. Two rules depend on the requester. An upgrade from a cache that no longer holds a shared copy is demoted to a plain write. A writeback from a cache that is not in the sharer set is marked stale. When the line is absent and the set is full, the request itself is not classified. The block instead reports an eviction of the victim way, split by the victim's dirty bit, and flags that the event targets the victim rather than the requested line. Tag lookup and victim selection happen elsewhere.

Top module: `coh_req_classifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `evt_valid`, `req_err`, `evt_victim` are 0 and `evt_code` is 0.
- R2: A request sampled with `req_valid`=1 on a rising edge produces, in the next cycle only, exactly one of `evt_valid`=1 or `req_err`=1. With no request, both are 0, `evt_code` is 0 and `evt_victim` is 0.
- R3: Request kinds use the encoding read=0, instruction read=1, write=2, upgrade=3, writeback=4. Event codes are read=0, instruction read=1, write=2, upgrade=3, writeback=4, stale writeback=5, dirty eviction=6, clean eviction=7. When the line is resident (`line_hit`=1), or absent with `way_free`=1, a read gives code 0, an instruction read gives 1 and a write gives 2, each with `evt_victim`=0.
- R4: A requester is a sharer exactly when `req_id` < NUM_REQ and bit `req_id` of `sharer_mask` is 1. An upgrade from a sharer gives code 3.
- R5: An upgrade from a non-sharer gives code 2 (write).
- R6: A writeback from a sharer gives code 4. From a non-sharer it gives code 5.
- R7: When `line_hit`=0 and `way_free`=0, any valid request kind gives `evt_victim`=1. The code is 6 if `victim_dirty`=1 and 7 otherwise, whatever the kind and sharer status.
- R8: When `line_hit`=1 or `way_free`=1, `victim_dirty` has no effect on the outputs.
- R9: Kinds 5, 6 and 7 raise `req_err` for one cycle with `evt_valid`=0, `evt_code`=0 and `evt_victim`=0, even when the set is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_type | input | 3 | Request kind |
| req_id | input | ID_W | Requesting cache ID |
| line_hit | input | 1 | Addressed line is resident |
| sharer_mask | input | NUM_REQ | Sharer bit-vector of the line, one bit per cache ID |
| way_free | input | 1 | Indexed set has an unused way |
| victim_dirty | input | 1 | Dirty bit of the chosen victim way |
| evt_valid | output | 1 | Event valid |
| evt_code | output | 3 | Event code |
| evt_victim | output | 1 | Event targets the victim line, not the requested line |
| req_err | output | 1 | Request kind was not recognised |

## Verification
The bench targets the requester-dependent demotions: upgrades and writebacks where the mask has bits set for other IDs but not the requester's own. A design that tested any bit of the mask would report an upgrade or a fresh writeback here. It also drives full sets with resident lines and with free ways, where a design with wrong eviction priority would report evictions. It drives full sets with every request kind, including upgrades and writebacks, where classifying the request before the eviction check would leak a normal code. Finally, it sends invalid kinds against full sets, where a design that checked eviction first would report an eviction instead of an error. Back-to-back requests and idle gaps expose any event that lingers or arrives a cycle late.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam logic [2:0] RQ_READ    = 3'd0;
  localparam logic [2:0] RQ_IFETCH  = 3'd1;
  localparam logic [2:0] RQ_WRITE   = 3'd2;
  localparam logic [2:0] RQ_UPGRADE = 3'd3;
  localparam logic [2:0] RQ_WRBACK  = 3'd4;

  typedef enum logic [2:0] {
    EV_READ        = 3'd0,
    EV_IFETCH      = 3'd1,
    EV_WRITE       = 3'd2,
    EV_UPGRADE     = 3'd3,
    EV_WRBACK      = 3'd4,
    EV_WRBACK_OLD  = 3'd5,
    EV_EVICT_DIRTY = 3'd6,
    EV_EVICT_CLEAN = 3'd7
  } ev_e;

  typedef struct packed {
    logic bad;
    logic victim;
    ev_e  code;
  } cls_t;

  function automatic logic kind_known(input logic [2:0] t);
    return t <= RQ_WRBACK;
  endfunction

  // Event selection: bad kind first, then full-set eviction, then per-kind rules.
  function automatic cls_t classify(input logic [2:0] t, input logic sharer,
                                    input logic hit, input logic free,
                                    input logic vdirty);
    cls_t r;
    r.bad    = 1'b0;
    r.victim = 1'b0;
    r.code   = EV_READ;
    if (!kind_known(t)) begin
      r.bad = 1'b1;
    end else if (!hit && !free) begin
      r.victim = 1'b1;
      r.code   = vdirty ? EV_EVICT_DIRTY : EV_EVICT_CLEAN;
    end else begin
      case (t)
        RQ_READ:    r.code = EV_READ;
        RQ_IFETCH:  r.code = EV_IFETCH;
        RQ_WRITE:   r.code = EV_WRITE;
        RQ_UPGRADE: r.code = sharer ? EV_UPGRADE : EV_WRITE;
        RQ_WRBACK:  r.code = sharer ? EV_WRBACK : EV_WRBACK_OLD;
        default:    r.code = EV_READ;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_req_stage.sv
module crc_req_stage #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         in_type,
  input  logic [ID_W-1:0]    in_id,
  input  logic [NUM_REQ-1:0] in_mask,
  input  logic               in_hit,
  input  logic               in_free,
  input  logic               in_vdirty,
  output logic               q_valid,
  output logic [2:0]         q_type,
  output logic [ID_W-1:0]    q_id,
  output logic [NUM_REQ-1:0] q_mask,
  output logic               q_hit,
  output logic               q_free,
  output logic               q_vdirty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_type   <= '0;
      q_id     <= '0;
      q_mask   <= '0;
      q_hit    <= 1'b0;
      q_free   <= 1'b0;
      q_vdirty <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_type   <= in_type;
        q_id     <= in_id;
        q_mask   <= in_mask;
        q_hit    <= in_hit;
        q_free   <= in_free;
        q_vdirty <= in_vdirty;
      end
    end
  end

endmodule

// File: rtl/crc_sharer_match.sv
module crc_sharer_match #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic [ID_W-1:0]    id,
  input  logic [NUM_REQ-1:0] mask,
  output logic               is_sharer
);

  logic [NUM_REQ-1:0] sel_vec;

  // One comparator per cache ID. IDs at or above NUM_REQ match no bit.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
    assign sel_vec[i] = mask[i] && (id == ID_W'(i));
  end

  assign is_sharer = |sel_vec;

endmodule

// File: rtl/crc_event_decode.sv
module crc_event_decode
  import crc_pkg::*;
(
  input  logic       q_valid,
  input  logic [2:0] q_type,
  input  logic       sharer,
  input  logic       hit,
  input  logic       free,
  input  logic       vdirty,
  output logic       evt_valid,
  output logic [2:0] evt_code,
  output logic       evt_victim,
  output logic       bad_kind
);

  cls_t cls;

  always_comb begin
    cls        = classify(q_type, sharer, hit, free, vdirty);
    evt_valid  = q_valid && !cls.bad;
    evt_code   = evt_valid ? cls.code : 3'd0;
    evt_victim = evt_valid && cls.victim;
    bad_kind   = q_valid && cls.bad;
  end

endmodule

// File: rtl/coh_req_classifier.sv
module coh_req_classifier
  import crc_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_type,
  input  logic [ID_W-1:0]    req_id,
  input  logic               line_hit,
  input  logic [NUM_REQ-1:0] sharer_mask,
  input  logic               way_free,
  input  logic               victim_dirty,
  output logic               evt_valid,
  output logic [2:0]         evt_code,
  output logic               evt_victim,
  output logic               req_err
);

  logic               q_valid;
  logic [2:0]         q_type;
  logic [ID_W-1:0]    q_id;
  logic [NUM_REQ-1:0] q_mask;
  logic               q_hit;
  logic               q_free;
  logic               q_vdirty;
  logic               sharer_hit;

  crc_req_stage #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .in_type  (req_type),
    .in_id    (req_id),
    .in_mask  (sharer_mask),
    .in_hit   (line_hit),
    .in_free  (way_free),
    .in_vdirty(victim_dirty),
    .q_valid  (q_valid),
    .q_type   (q_type),
    .q_id     (q_id),
    .q_mask   (q_mask),
    .q_hit    (q_hit),
    .q_free   (q_free),
    .q_vdirty (q_vdirty)
  );

  crc_sharer_match #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_match (
    .id       (q_id),
    .mask     (q_mask),
    .is_sharer(sharer_hit)
  );

  crc_event_decode u_dec (
    .q_valid   (q_valid),
    .q_type    (q_type),
    .sharer    (sharer_hit),
    .hit       (q_hit),
    .free      (q_free),
    .vdirty    (q_vdirty),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_victim(evt_victim),
    .bad_kind  (req_err)
  );

  AST_EVT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    (evt_valid || req_err) |-> $past(req_valid)) else $error("evt without req"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |-> (evt_code == 3'd0 && !evt_victim)) else $error("idle outputs"); // R2
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (rst)
    req_err |-> ($past(req_type) > 3'd4 && !evt_valid)) else $error("err kind"); // R9
  AST_UPG_NEEDS_SHARER: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_UPGRADE) |-> sharer_hit) else $error("upgrade"); // R4
  AST_STALE_NOT_SHARER: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_WRBACK_OLD) |-> !sharer_hit) else $error("stale wb"); // R6
  AST_EVICT_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    evt_victim |-> $past(!line_hit && !way_free)) else $error("evict cond"); // R7
  AST_EVICT_CODE: assert property (@(posedge clk) disable iff (rst)
    evt_victim |-> (evt_code == ($past(victim_dirty) ? 3'd6 : 3'd7))) else $error("evict code"); // R7

endmodule

// File: tb/tb_coh_req_classifier.sv
module tb_coh_req_classifier;

  localparam int CLK_P   = 10;
  localparam int NUM_REQ = 8;
  localparam int ID_W    = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [2:0]         req_type = '0;
  logic [ID_W-1:0]    req_id = '0;
  logic               line_hit = 1'b0;
  logic [NUM_REQ-1:0] sharer_mask = '0;
  logic               way_free = 1'b0;
  logic               victim_dirty = 1'b0;
  logic               evt_valid, evt_victim, req_err;
  logic [2:0]         evt_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values for the next sample
  logic       x_v = 0, x_e = 0, x_vic = 0;
  int         x_code = 0;
  string      x_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  coh_req_classifier #(.NUM_REQ(NUM_REQ)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_id(req_id), .line_hit(line_hit), .sharer_mask(sharer_mask),
    .way_free(way_free), .victim_dirty(victim_dirty),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_victim(evt_victim),
    .req_err(req_err)
  );

  task automatic compare();
    checks++;
    if (evt_valid !== x_v || req_err !== x_e || evt_victim !== x_vic ||
        int'(evt_code) != x_code) begin
      fails++;
      $display("FAIL %s: actual v=%0b e=%0b code=%0d vic=%0b expected v=%0b e=%0b code=%0d vic=%0b",
               x_tag, evt_valid, req_err, evt_code, evt_victim, x_v, x_e, x_code, x_vic);
    end
  endtask

  // Reference: behavioural statement of the requirements.
  task automatic predict(bit in_rst, bit v, int t, int id, logic [NUM_REQ-1:0] m,
                         bit hit, bit free, bit vd);
    bit owns;
    x_v = 0; x_e = 0; x_vic = 0; x_code = 0;
    owns = (id < NUM_REQ) ? m[id] : 1'b0;
    if (in_rst) begin x_tag = "R1"; return; end
    if (!v) begin x_tag = "R2"; return; end
    if (t >= 5) begin x_e = 1; x_tag = "R9"; return; end
    x_v = 1;
    if (!hit && !free) begin
      x_vic = 1; x_code = vd ? 6 : 7; x_tag = "R7"; return;
    end
    x_tag = vd ? "R8" : "R3";
    if (t == 3) begin
      x_code = owns ? 3 : 2; x_tag = owns ? "R4" : "R5";
    end else if (t == 4) begin
      x_code = owns ? 4 : 5; x_tag = "R6";
    end else x_code = t;
  endtask

  task automatic step(bit r, bit v, int t, int id, logic [NUM_REQ-1:0] m,
                      bit hit, bit free, bit vd);
    @(negedge clk);
    compare();
    rst = r; req_valid = v; req_type = 3'(t); req_id = ID_W'(id);
    sharer_mask = m; line_hit = hit; way_free = free; victim_dirty = vd;
    predict(r, v, t, id, m, hit, free, vd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset, with a request presented during reset
    step(1, 1, 2, 0, '0, 1, 0, 0);
    step(1, 0, 0, 0, '0, 0, 0, 0);
    step(0, 0, 0, 0, '0, 0, 0, 0);
    // R3: own-line kinds, hit and miss-with-free-way
    step(0, 1, 0, 1, 8'h00, 1, 0, 0);
    step(0, 1, 1, 2, 8'h00, 0, 1, 0);
    step(0, 1, 2, 3, 8'hFF, 1, 1, 0);
    // R4 / R5: upgrade sharer vs neighbour-bit-only
    step(0, 1, 3, 5, 8'h20, 1, 0, 0);
    step(0, 1, 3, 5, 8'hDF, 1, 0, 0);
    step(0, 1, 3, 0, 8'h01, 0, 1, 0);
    // R6: writeback sharer vs stale
    step(0, 1, 4, 7, 8'h80, 1, 0, 0);
    step(0, 1, 4, 7, 8'h7F, 1, 0, 0);
    // R8: dirty victim ignored when resident or free
    step(0, 1, 0, 2, 8'h00, 1, 0, 1);
    step(0, 1, 4, 2, 8'h04, 0, 1, 1);
    // R7: full set, every kind, both dirty states
    for (int k = 0; k < 5; k++) begin
      step(0, 1, k, 3, 8'h08, 0, 0, 1);
      step(0, 1, k, 3, 8'h08, 0, 0, 0);
    end
    // R9: invalid kinds, including full sets
    for (int k = 5; k < 8; k++) begin
      step(0, 1, k, 1, 8'h02, 0, 0, 1);
      step(0, 0, 0, 0, '0, 0, 0, 0);
    end
    // R2: idle gap then back-to-back
    step(0, 0, 3, 1, 8'hFF, 1, 0, 0);
    step(0, 1, 3, 1, 8'h02, 1, 0, 0);
    step(0, 1, 4, 1, 8'h00, 1, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      step(0, ($urandom % 4) != 0, $urandom % 8, $urandom % NUM_REQ,
           NUM_REQ'($urandom), $urandom % 2, $urandom % 2, $urandom % 2);
    end
    step(0, 0, 0, 0, '0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule